// File: doc/BRIEF.md
# Two-Slot Wide-Word Execution Core

This core runs straight-line and branching programs made of 64-bit instruction words. Each word carries two independent 32-bit operations, and both complete in one clock cycle. An operation can be an add, subtract, bitwise and, bitwise or, a predicated select, or a conditional branch on equality or inequality. The two slots share one register file. Both slots read their sources from the state as it stood before the word, so a result produced in one slot is not visible to the other slot in the same word.

Instructions come from a combinational read port. The core presents the program counter as the fetch address and receives the word in the same cycle. A debug read port returns any register's current value. It allows a test environment to observe the architected state without stopping the core. Synchronous reset puts the program counter at zero and loads every register with its own index. The first program therefore has known, distinct operand values.

Top module: `vliw2_core`

## Requirements
- R1: While `rst` is high at a clock edge, the core moves the program counter (`imem_addr`) to 0 and loads register k with the value k for every k from 0 to 31.
- R2: A word with no taken branch advances `imem_addr` by 8 on the next edge. The fetch address is always a multiple of 8.
- R3: Both slots read their sources before either slot writes. Starting from reset, the word {ADD r8,r9,r10 ; ADD r7,r8,r9} leaves r8=19 and r7=17.
- R4: The first slot occupies bits 63:32 and the second occupies bits 31:0. Within a slot, bits 31:26 are the opcode, 25:21 rs, 20:16 rt, 15:11 rd, 10:6 the fourth register index and 5:0 the function code. With opcode 0x00, the function codes 0x20, 0x22, 0x24 and 0x25 write rs+rt, rs-rt (mod 2^32), rs AND rt and rs OR rt to rd.
- R5: Opcode 0x00 with function code 0x0B selects. It writes the register named by bits 10:6 to rd when rs holds zero, and otherwise writes rt.
- R6: Opcode 0x04 branches when rs equals rt, and opcode 0x05 branches when they differ. The target is the word's address plus 8 plus the sign-extended 16-bit immediate (bits 15:0) shifted left by 3. Words that are skipped have no effect.
- R7: A non-branch operation that shares a word with a branch commits whether or not the branch is taken.
- R8: With a branch in both slots, a taken first slot wins. The second slot's branch decides the next address only when the first is not taken.
- R9: When both slots write the same non-zero register, the second slot's value is kept. Writes to register 0 are discarded, and it always reads 0.
- R10: Any other opcode or function code makes that slot do nothing. The other slot still executes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the current instruction word (program counter) |
| imem_data | input | 64 | Instruction word at `imem_addr`, valid in the same cycle |
| dbg_idx | input | 5 | Register index for the debug read |
| dbg_val | output | 32 | Current value of register `dbg_idx` (combinational) |

## Verification
A wrong program counter shows on `imem_addr` at the very next edge, and from then on every later word executes along the wrong path. A corrupted register is not visible until it is read on the debug port or used as a source. That is why the full register file is compared against the reference after every cycle, and a bad write is caught one edge after it happens. Poison words placed on every skipped path turn a branch that falls through wrongly into a register difference at once. Values chosen so that a forwarded result differs from the pre-word value expose any read-after-write mix-up between the slots in the first cycle after reset.

// File: rtl/vliw2_pkg.sv
package vliw2_pkg;
    localparam int XLEN        = 32;
    localparam int NREG        = 32;
    localparam int RIDX        = $clog2(NREG);
    localparam int NSLOT       = 2;
    localparam int OPW         = 32;
    localparam int WORDW       = NSLOT * OPW;
    localparam int IMMW        = 16;
    localparam int STEP_BYTES  = WORDW / 8;
    localparam int STEP_SHIFT  = $clog2(STEP_BYTES);
    localparam int SRC_PER_SLOT = 3;
    localparam int NRPORT      = NSLOT * SRC_PER_SLOT + 1;
    localparam int DBG_PORT    = NRPORT - 1;

    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] OPC_BNE   = 6'h05;
    localparam logic [5:0] FN_ADD    = 6'h20;
    localparam logic [5:0] FN_SUB    = 6'h22;
    localparam logic [5:0] FN_AND    = 6'h24;
    localparam logic [5:0] FN_OR     = 6'h25;
    localparam logic [5:0] FN_SEL    = 6'h0B;

    typedef enum logic [2:0] {
        OP_NOP, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_SEL, OP_BEQ, OP_BNE
    } slot_op_e;

    typedef struct packed {
        slot_op_e          op;
        logic [RIDX-1:0]   rs;
        logic [RIDX-1:0]   rt;
        logic [RIDX-1:0]   rd;
        logic [RIDX-1:0]   ru;
        logic [IMMW-1:0]   imm;
    } slot_ctl_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;
endpackage

// File: rtl/vliw2_decode.sv
module vliw2_decode
    import vliw2_pkg::*;
(
    input  logic [OPW-1:0] op_word,
    output slot_ctl_t      ctl
);
    logic [5:0] opc;
    logic [5:0] fn;

    assign opc = op_word[31:26];
    assign fn  = op_word[5:0];

    always_comb begin
        ctl.rs  = op_word[25:21];
        ctl.rt  = op_word[20:16];
        ctl.rd  = op_word[15:11];
        ctl.ru  = op_word[10:6];
        ctl.imm = op_word[IMMW-1:0];
        ctl.op  = OP_NOP;
        case (opc)
            OPC_RTYPE: begin
                case (fn)
                    FN_ADD:  ctl.op = OP_ADD;
                    FN_SUB:  ctl.op = OP_SUB;
                    FN_AND:  ctl.op = OP_AND;
                    FN_OR:   ctl.op = OP_OR;
                    FN_SEL:  ctl.op = OP_SEL;
                    default: ctl.op = OP_NOP;
                endcase
            end
            OPC_BEQ: ctl.op = OP_BEQ;
            OPC_BNE: ctl.op = OP_BNE;
            default: ctl.op = OP_NOP;
        endcase
    end
endmodule

// File: rtl/vliw2_slot_exec.sv
module vliw2_slot_exec
    import vliw2_pkg::*;
(
    input  slot_ctl_t        ctl,
    input  logic [XLEN-1:0]  pc,
    input  logic [XLEN-1:0]  src_s,
    input  logic [XLEN-1:0]  src_t,
    input  logic [XLEN-1:0]  src_u,
    output logic             wr_en,
    output logic [RIDX-1:0]  wr_idx,
    output logic [XLEN-1:0]  wr_val,
    output logic             br_take,
    output logic [XLEN-1:0]  br_target
);
    logic [XLEN-1:0] offset;
    logic            same;

    assign offset    = {{(XLEN-IMMW){ctl.imm[IMMW-1]}}, ctl.imm} << STEP_SHIFT;
    assign br_target = pc + XLEN'(STEP_BYTES) + offset;
    assign same      = (src_s == src_t);
    assign wr_idx    = ctl.rd;

    always_comb begin
        wr_en   = 1'b0;
        wr_val  = '0;
        br_take = 1'b0;
        case (ctl.op)
            OP_ADD: begin wr_en = 1'b1; wr_val = src_s + src_t; end
            OP_SUB: begin wr_en = 1'b1; wr_val = src_s - src_t; end
            OP_AND: begin wr_en = 1'b1; wr_val = src_s & src_t; end
            OP_OR:  begin wr_en = 1'b1; wr_val = src_s | src_t; end
            OP_SEL: begin
                wr_en  = 1'b1;
                wr_val = (src_s == '0) ? src_u : src_t;
            end
            OP_BEQ: br_take = same;
            OP_BNE: br_take = !same;
            default: ;
        endcase
    end
endmodule

// File: rtl/vliw2_regfile.sv
module vliw2_regfile
    import vliw2_pkg::*;
#(
    parameter int NRP = NRPORT,
    parameter int NWP = NSLOT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [RIDX-1:0] rd_idx [NRP],
    output logic [XLEN-1:0] rd_val [NRP],
    input  logic            wr_en  [NWP],
    input  logic [RIDX-1:0] wr_idx [NWP],
    input  logic [XLEN-1:0] wr_val [NWP]
);
    logic [XLEN-1:0] regs_d [NREG];
    logic [XLEN-1:0] regs_q [NREG];

    always_comb begin
        regs_d = regs_q;
        // later write ports override earlier ones
        for (int w = 0; w < NWP; w++) begin
            if (wr_en[w] && (wr_idx[w] != '0)) begin
                regs_d[wr_idx[w]] = wr_val[w];
            end
        end
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                regs_d[i] = XLEN'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    for (genvar p = 0; p < NRP; p++) begin : g_rd
        assign rd_val[p] = (rd_idx[p] == '0) ? '0 : regs_q[rd_idx[p]];
    end
endmodule

// File: rtl/vliw2_core.sv
module vliw2_core
    import vliw2_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    output logic [XLEN-1:0]  imem_addr,
    input  logic [WORDW-1:0] imem_data,
    input  logic [RIDX-1:0]  dbg_idx,
    output logic [XLEN-1:0]  dbg_val
);
    core_state_t state_d, state_q;

    slot_ctl_t       ctl       [NSLOT];
    logic [RIDX-1:0] rf_ridx   [NRPORT];
    logic [XLEN-1:0] rf_rval   [NRPORT];
    logic            rf_wen    [NSLOT];
    logic [RIDX-1:0] rf_widx   [NSLOT];
    logic [XLEN-1:0] rf_wval   [NSLOT];
    logic            br_take   [NSLOT];
    logic [XLEN-1:0] br_target [NSLOT];

    assign imem_addr = state_q.pc;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        localparam int HI   = (NSLOT - s) * OPW - 1;
        localparam int BASE = s * SRC_PER_SLOT;

        vliw2_decode i_dec (
            .op_word (imem_data[HI -: OPW]),
            .ctl     (ctl[s])
        );

        assign rf_ridx[BASE + 0] = ctl[s].rs;
        assign rf_ridx[BASE + 1] = ctl[s].rt;
        assign rf_ridx[BASE + 2] = ctl[s].ru;

        vliw2_slot_exec i_exe (
            .ctl       (ctl[s]),
            .pc        (state_q.pc),
            .src_s     (rf_rval[BASE + 0]),
            .src_t     (rf_rval[BASE + 1]),
            .src_u     (rf_rval[BASE + 2]),
            .wr_en     (rf_wen[s]),
            .wr_idx    (rf_widx[s]),
            .wr_val    (rf_wval[s]),
            .br_take   (br_take[s]),
            .br_target (br_target[s])
        );
    end

    assign rf_ridx[DBG_PORT] = dbg_idx;
    assign dbg_val           = rf_rval[DBG_PORT];

    vliw2_regfile #(.NRP(NRPORT), .NWP(NSLOT)) i_rf (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (rf_ridx),
        .rd_val (rf_rval),
        .wr_en  (rf_wen),
        .wr_idx (rf_widx),
        .wr_val (rf_wval)
    );

    always_comb begin
        logic found;
        found      = 1'b0;
        state_d.pc = state_q.pc + XLEN'(STEP_BYTES);
        // earliest slot with a taken branch decides
        for (int s = 0; s < NSLOT; s++) begin
            if (!found && br_take[s]) begin
                state_d.pc = br_target[s];
                found      = 1'b1;
            end
        end
        if (rst) begin
            state_d.pc = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end
endmodule

// File: rtl/vliw2_core_chk.sv
module vliw2_core_chk
    import vliw2_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [XLEN-1:0]  imem_addr,
    input logic [WORDW-1:0] imem_data,
    input logic [RIDX-1:0]  dbg_idx,
    input logic [XLEN-1:0]  dbg_val
);
    logic [5:0]      opc_a, opc_b;
    logic            any_branch;
    logic            a_always_taken;
    logic [XLEN-1:0] a_target;

    assign opc_a          = imem_data[63:58];
    assign opc_b          = imem_data[31:26];
    assign any_branch     = (opc_a == OPC_BEQ) || (opc_a == OPC_BNE) ||
                            (opc_b == OPC_BEQ) || (opc_b == OPC_BNE);
    assign a_always_taken = (opc_a == OPC_BEQ) && (imem_data[57:53] == imem_data[52:48]);
    assign a_target       = imem_addr + XLEN'(STEP_BYTES) +
                            ({{(XLEN-IMMW){imem_data[47]}}, imem_data[47:32]} << STEP_SHIFT);

    a_r1_reset_pc: assert property (@(posedge clk) rst |=> imem_addr == '0);

    a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
        !any_branch |=> imem_addr == $past(imem_addr) + XLEN'(STEP_BYTES));

    a_r2_aligned: assert property (@(posedge clk) disable iff (rst)
        imem_addr[STEP_SHIFT-1:0] == '0);

    a_r8_first_slot_wins: assert property (@(posedge clk) disable iff (rst)
        a_always_taken |=> imem_addr == $past(a_target));

    a_r9_zero_reg: assert property (@(posedge clk) disable iff (rst)
        dbg_idx == '0 |-> dbg_val == '0);
endmodule

bind vliw2_core vliw2_core_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .imem_addr (imem_addr),
    .imem_data (imem_data),
    .dbg_idx   (dbg_idx),
    .dbg_val   (dbg_val)
);

// File: tb/test_vliw2_core.sv
`timescale 1ns/1ps
module test_vliw2_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr;
    logic [63:0] imem_data;
    logic [4:0]  dbg_idx = '0;
    logic [31:0] dbg_val;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [63:0] prog [32];
    logic [31:0] mreg [32];
    logic [31:0] mpc;

    always #2.5 clk = ~clk;

    vliw2_core i_vliw2_core (
        .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
        .dbg_idx(dbg_idx), .dbg_val(dbg_val)
    );

    function automatic logic [63:0] fetch(logic [31:0] a);
        if (a < 32'd256) return prog[a[7:3]];
        return 64'd0;
    endfunction

    assign imem_data = fetch(imem_addr);

    function automatic logic [31:0] rop(logic [5:0] fn, int rd, int rs, int rt, int ru);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(ru), fn};
    endfunction
    function automatic logic [31:0] bop(logic [5:0] opc, int rs, int rt, int off);
        return {opc, 5'(rs), 5'(rt), 16'(off)};
    endfunction

    task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic read_reg(int idx, output logic [31:0] v);
        dbg_idx = 5'(idx);
        #0.05;
        v = dbg_val;
    endtask

    task automatic compare_all(string pc_tag, string reg_tag);
        logic [31:0] v;
        check(pc_tag, "pc", imem_addr, mpc);
        for (int r = 0; r < 32; r++) begin
            read_reg(r, v);
            check(reg_tag, $sformatf("r%0d", r), v, mreg[r]);
        end
    endtask

    task automatic model_step(output string tag);
        logic [63:0] w;
        logic [31:0] old [32];
        logic [31:0] opw, a, b, c, res, npc;
        logic [5:0]  opc, fn;
        int rs, rt, rd, ru, nbr;
        bit taken, ok;
        w = fetch(mpc);
        old = mreg;
        npc = mpc + 32'd8;
        taken = 0;
        nbr = 0;
        for (int s = 0; s < 2; s++) begin
            opw = (s == 0) ? w[63:32] : w[31:0];
            opc = opw[31:26]; fn = opw[5:0];
            rs = int'(opw[25:21]); rt = int'(opw[20:16]);
            rd = int'(opw[15:11]); ru = int'(opw[10:6]);
            a = old[rs]; b = old[rt]; c = old[ru];
            ok = 0; res = 0;
            if (opc == 6'h00) begin
                ok = 1;
                if (fn == 6'h20) res = a + b;
                else if (fn == 6'h22) res = a - b;
                else if (fn == 6'h24) res = a & b;
                else if (fn == 6'h25) res = a | b;
                else if (fn == 6'h0B) res = (a == 0) ? c : b;
                else ok = 0;
                if (ok && rd != 0) mreg[rd] = res;
            end else if (opc == 6'h04 || opc == 6'h05) begin
                nbr++;
                if (((opc == 6'h04) ? (a == b) : (a != b)) && !taken) begin
                    taken = 1;
                    npc = mpc + 32'd8 + ({{16{opw[15]}}, opw[15:0]} << 3);
                end
            end
        end
        mpc = npc;
        tag = (nbr == 2) ? "R8" : (nbr == 1) ? "R6" : "R2";
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        string tag;
        logic [63:0] poison;
        poison = {rop(6'h20, 24, 24, 1, 0), rop(6'h20, 29, 29, 1, 0)};
        for (int i = 0; i < 32; i++) prog[i] = 64'd0;
        prog[0]  = {rop(6'h20, 8, 9, 10, 0),  rop(6'h20, 7, 8, 9, 0)};
        prog[1]  = {rop(6'h22, 11, 1, 2, 0),  rop(6'h24, 12, 13, 14, 0)};
        prog[2]  = {rop(6'h25, 15, 16, 3, 0), rop(6'h0B, 17, 0, 5, 6)};
        prog[3]  = {rop(6'h0B, 18, 1, 5, 6),  rop(6'h20, 19, 19, 19, 0)};
        prog[4]  = {rop(6'h20, 20, 1, 1, 0),  rop(6'h20, 20, 2, 2, 0)};
        prog[5]  = {rop(6'h20, 0, 1, 1, 0),   rop(6'h3F, 21, 1, 2, 0)};
        prog[6]  = {6'h3E, 26'h02C0000,       rop(6'h20, 22, 1, 22, 0)};
        prog[7]  = {bop(6'h04, 1, 1, 2),      rop(6'h20, 23, 1, 1, 0)};
        prog[8]  = poison;
        prog[9]  = poison;
        prog[10] = {bop(6'h05, 1, 1, 5),      rop(6'h20, 25, 2, 3, 0)};
        prog[11] = {bop(6'h04, 1, 2, 3),      bop(6'h05, 1, 2, 1)};
        prog[12] = poison;
        prog[13] = {bop(6'h04, 1, 1, 2),      bop(6'h04, 1, 1, 4)};
        prog[14] = poison;
        prog[15] = poison;
        prog[16] = {bop(6'h05, 1, 2, 2),      rop(6'h20, 26, 1, 3, 0)};
        prog[17] = poison;
        prog[18] = {rop(6'h22, 28, 28, 1, 0), bop(6'h04, 0, 0, 0)};
        prog[19] = {rop(6'h20, 27, 27, 1, 0), bop(6'h04, 0, 0, -2)};

        rst = 1'b1;
        repeat (2) @(negedge clk);
        // R1: reset state, expected values written out directly
        check("R1", "pc", imem_addr, 32'd0);
        for (int r = 0; r < 32; r++) begin
            read_reg(r, v);
            check("R1", $sformatf("r%0d", r), v, 32'(r));
        end
        mpc = 32'd0;
        for (int r = 0; r < 32; r++) mreg[r] = 32'(r);
        rst = 1'b0;

        for (int cyc = 1; cyc <= 60; cyc++) begin
            model_step(tag);
            @(negedge clk);
            compare_all(tag, "R4");
            if (cyc == 1) begin
                read_reg(8, v); check("R3", "r8", v, 32'd19);
                read_reg(7, v); check("R3", "r7", v, 32'd17);
            end
        end

        read_reg(11, v); check("R4", "r11 sub", v, 32'hFFFF_FFFF);
        read_reg(12, v); check("R4", "r12 and", v, 32'd12);
        read_reg(15, v); check("R4", "r15 or", v, 32'd19);
        read_reg(17, v); check("R5", "r17 sel zero", v, 32'd6);
        read_reg(18, v); check("R5", "r18 sel nonzero", v, 32'd5);
        read_reg(24, v); check("R6", "r24 skipped", v, 32'd24);
        read_reg(29, v); check("R6", "r29 skipped", v, 32'd29);
        read_reg(23, v); check("R7", "r23 taken", v, 32'd2);
        read_reg(25, v); check("R7", "r25 not taken", v, 32'd5);
        read_reg(26, v); check("R8", "r26", v, 32'd4);
        read_reg(20, v); check("R9", "r20 both", v, 32'd4);
        read_reg(0, v);  check("R9", "r0", v, 32'd0);
        read_reg(21, v); check("R10", "r21 bad fn", v, 32'd21);
        read_reg(22, v); check("R10", "r22 other slot", v, 32'd23);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule